// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Unit

This unit watches eleven I/O pin values and raises a single shared pin-change interrupt when any watched pin toggles. The pins fall into two groups. Each group has its own enable bit, and that bit gates the flag itself, not only the request. A group that is switched off cannot leave a pending flag behind that would fire later. A pin whose alternate function is active is dropped from detection. The per-pin alternate-function state arrives as several independent condition vectors, and the unit ORs them for each pin.

Pin values are asynchronous, so each one passes through a two-flop synchronizer. A change is detected when the synchronized value differs from the value held one cycle earlier. This history register updates every cycle whatever the enables and masks are. Turning on a group, or releasing an alternate function, therefore cannot replay an edge that happened while the pin was masked. The flag holds until software strobes the clear input. A qualified change in the same cycle as the clear wins over the clear. The request output is a level that follows the flag. Other interrupt sources that the same pin edge may trigger are not affected in any way.

Top module: `pcint_unit`

## Requirements
- R1: Each pin is synchronized by two flops. A change on `pin_i` that is set up before rising edge k raises `flag_o` after edge k+2, and not earlier.
- R2: Pins are grouped by bit position. Bits 3..0 of `pin_i` belong to group 0, enabled by `grp_en_i[0]`. Bits 10..4 belong to group 1, enabled by `grp_en_i[1]`. In port terms, bits 7..0 are port B bits 7..0, bit 8 is port A bit 3, bit 9 is port A bit 6 and bit 10 is port A bit 7.
- R3: While a pin's group enable is 0, changes on that pin never set `flag_o`. The enable gates the flag, not just the request.
- R4: Bit c*11+p of `alt_cond_i` is alternate-function condition c (c = 0..2) for pin p. Any single condition set for pin p stops changes on pin p from setting the flag.
- R5: Once set, `flag_o` stays at 1 until `flag_clr_i` is sampled high. With no new change in that cycle, the flag reads 0 after that edge.
- R6: When a qualified change and `flag_clr_i` fall in the same cycle, the flag is set or stays set.
- R7: A pin that changed while its group was disabled, or while it was masked, produces no event once it is enabled or unmasked. A later change on that pin is detected normally.
- R8: After reset, `flag_o` and `irq_o` are 0. Pin levels present when reset is released do not cause an event.
- R9: `irq_o` equals `flag_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 11 | Asynchronous pin values being watched |
| alt_cond_i | input | 33 | Alternate-function conditions: 3 vectors of 11 pins each, bit c*11+p |
| grp_en_i | input | 2 | Group enables, bit g for group g |
| flag_clr_i | input | 1 | Clears the pin-change flag |
| flag_o | output | 1 | Sticky pin-change flag |
| irq_o | output | 1 | Interrupt request level |

## Verification
A wrong history or synchronizer state appears at `flag_o` as a spurious or missing flag. It is seen exactly three edges after the pin edge, or three edges after reset when the history is not primed. Both are sampled at that cycle. A wrong group map or masking decode appears in a single sweep, which checks every pin against every enable combination with and without an alternate condition. Each case has one expected flag value. A broken set-versus-clear priority or a broken stickiness shows on the very next edge. The bench provokes both at that edge.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int unsigned PC_NUM_PINS = 11;
  localparam int unsigned PC_NUM_ALT  = 3;
  localparam int unsigned PC_NUM_GRP  = 2;
  // 1 marks a group-1 pin
  localparam logic [PC_NUM_PINS-1:0] PC_GRP1_MAP = 11'h7F0;
  localparam int unsigned PC_PRIME_CYC = 3;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/pcint_detect.sv
module pcint_detect
  import pcint_pkg::*;
#(
  parameter int unsigned NPIN = PC_NUM_PINS,
  parameter int unsigned NALT = PC_NUM_ALT,
  parameter logic [NPIN-1:0] GRP1_MAP = PC_GRP1_MAP,
  parameter int unsigned PRIME_CYC = PC_PRIME_CYC
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPIN-1:0]      sync_i,
  input  logic [NALT*NPIN-1:0] alt_cond_i,
  input  logic [1:0]           grp_en_i,
  output logic                 evt_o
);
  localparam int unsigned PW = $clog2(PRIME_CYC + 1);

  logic [NPIN-1:0] hist_q, chg, alt_pin, pin_en;
  logic [PW-1:0]   prime_q;
  logic            primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      prime_q <= '0;
    end else begin
      hist_q <= sync_i;  // always tracks, masks do not gate history
      if (!primed) prime_q <= prime_q + 1'b1;
    end
  end

  assign primed = (prime_q == PW'(PRIME_CYC));
  assign chg    = sync_i ^ hist_q;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NALT-1:0] conds;
    for (genvar c = 0; c < NALT; c++) begin : g_cond
      assign conds[c] = alt_cond_i[c*NPIN+p];
    end
    assign alt_pin[p] = |conds;
    assign pin_en[p]  = (GRP1_MAP[p] ? grp_en_i[1] : grp_en_i[0]) & ~alt_pin[p];
  end

  assign evt_o = primed & |(chg & pin_en);

  AST_GRP_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_en_i == 2'b00) |-> !evt_o);  // R3
  AST_ALT_ALL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&alt_cond_i[NPIN-1:0]) |-> !evt_o);  // R4
endmodule

// File: rtl/pcint_flag.sv
module pcint_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);  // set beats clear
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);  // R6
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);  // R5
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);  // R5
endmodule

// File: rtl/pcint_unit.sv
module pcint_unit
  import pcint_pkg::*;
#(
  parameter int unsigned NPIN = PC_NUM_PINS,
  parameter int unsigned NALT = PC_NUM_ALT,
  parameter logic [NPIN-1:0] GRP1_MAP = PC_GRP1_MAP
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NPIN-1:0]      pin_i,
  input  logic [NALT*NPIN-1:0] alt_cond_i,
  input  logic [1:0]           grp_en_i,
  input  logic                 flag_clr_i,
  output logic                 flag_o,
  output logic                 irq_o
);
  logic [NPIN-1:0] pin_sync;
  logic            evt;

  pcint_sync #(.W(NPIN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync)
  );

  pcint_detect #(.NPIN(NPIN), .NALT(NALT), .GRP1_MAP(GRP1_MAP)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(pin_sync),
    .alt_cond_i(alt_cond_i), .grp_en_i(grp_en_i), .evt_o(evt)
  );

  pcint_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(evt), .clr_i(flag_clr_i), .flag_o(flag_o)
  );

  assign irq_o = flag_o;

  AST_DISABLED_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && grp_en_i == 2'b00) |=> !flag_o);  // R3
  AST_STABLE_PINS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && $stable(pin_i) && $past(pin_i) == pin_i && !evt) |=> !flag_o);  // R1
endmodule

// File: tb/pcint_unit_tb_top.sv
module pcint_unit_tb_top;
  localparam int N = 11;
  localparam int NA = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pins = '1;
  logic [NA*N-1:0] alt = '0;
  logic [1:0] en = 2'b00;
  logic clr = 1'b0;
  logic flag, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcint_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .alt_cond_i(alt),
    .grp_en_i(en), .flag_clr_i(clr), .flag_o(flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: flag/irq actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req, input logic exp);
    chk(req, flag, exp);
    chk("R9", irq, flag);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_both("R8", 1'b0);
    en = 2'b11;
    settle();
    // R8: pins were high through reset and must not cause an event
    chk_both("R8", 1'b0);

    // R1 R2 R3 R4 sweep
    for (int p = 0; p < N; p++) begin
      for (int e = 0; e < 4; e++) begin
        for (int a = 0; a < 2; a++) begin
          logic exp;
          int g;
          g = (p >= 4) ? 1 : 0;
          en = e[1:0];
          alt = '0;
          if (a != 0) alt[(p % NA) * N + p] = 1'b1;
          settle();
          clear_flag();
          pins[p] = ~pins[p];
          repeat (2) @(negedge clk);
          chk("R1", flag, 1'b0);
          @(negedge clk);
          exp = en[g] && (a == 0);
          chk_both(g == 1 ? "R2/R3 group1" : "R2/R3 group0", exp);
          chk("R4", flag, exp);
        end
      end
    end
    alt = '0;

    // R4: every condition vector masks alone
    en = 2'b11;
    for (int c = 0; c < NA; c++) begin
      alt = '0;
      alt[c * N + 6] = 1'b1;
      settle();
      clear_flag();
      pins[6] = ~pins[6];
      settle();
      chk("R4", flag, 1'b0);
    end
    alt = '0;

    // R5: sticky, then cleared
    settle();
    clear_flag();
    pins[1] = ~pins[1];
    repeat (12) @(negedge clk);
    chk_both("R5", 1'b1);
    clear_flag();
    chk_both("R5", 1'b0);

    // R6: clear in the same cycle as the event
    settle();
    pins[9] = ~pins[9];
    repeat (2) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk_both("R6", 1'b1);
    clear_flag();
    chk("R6", flag, 1'b0);

    // R7: stale history after enable
    en = 2'b00;
    settle();
    clear_flag();
    pins[5] = ~pins[5];
    settle();
    en = 2'b11;
    settle();
    chk_both("R7", 1'b0);
    // R7: stale history after unmask
    alt[N + 2] = 1'b1;
    settle();
    pins[2] = ~pins[2];
    settle();
    alt = '0;
    settle();
    chk_both("R7", 1'b0);
    pins[2] = ~pins[2];
    settle();
    chk_both("R7", 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule